// File: doc/BRIEF.md
# Tributary Framing and Parity Error Monitor

This block keeps performance-monitoring counts for a set of multiplexed tributaries. Each tributary has two live counters. The first counts errors in the frame alignment word. The second counts parity bit errors. Once per received frame, the upstream framer raises a frame strobe for that tributary. With the strobe it presents how many alignment bits arrived in error, whether a parity error was seen, and whether the tributary is out of frame. Two global selects set how the alignment count is formed. One names the line format. The other chooses between counting every errored bit and counting each errored word once.

Software reads a tributary by pulsing its read strobe. In that cycle both live counters are copied into holding registers that stay steady until the next read, and the live counters restart. An error event that arrives in the same cycle as the read is not lost. It becomes the first content of the restarted counter. Counters stop at their largest value instead of wrapping.

Top module: `fec_monitor`

## Requirements
- R1: After reset, every holding register reads 0, and a first read of any tributary returns 0 for both counters.
- R2: With `fmt_sel`=0 (first line format), each accepted frame adds `err_bits` (the count of errored F and M bits) to the alignment counter, whatever the value of `word_mode`.
- R3: With `fmt_sel`=1 and `word_mode`=0, each accepted frame adds the number of errored alignment bits, `err_bits`, to the alignment counter.
- R4: With `fmt_sel`=1 and `word_mode`=1, each accepted frame adds 1 to the alignment counter when `err_bits` is nonzero, and 0 otherwise.
- R5: The parity counter adds 1 for each accepted frame with `par_err`=1 only while `fmt_sel`=1. With `fmt_sel`=0 it does not change.
- R6: A frame strobe on a tributary whose `oof` bit is 1 changes neither of its counters.
- R7: A counter that reaches 2^CNT_W-1 stays at that value under further increments.
- R8: A read strobe loads each holding register with the live counter value from before that cycle, and the live counter restarts from exactly the increment accepted in that same cycle. Holding registers change only on a read of their own tributary.
- R9: Tributaries are independent. Activity or reads on one tributary do not change another tributary's counts.
- R10: Input values presented without a frame strobe are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 1 | Line format: 0 = first format, 1 = second format |
| word_mode | input | 1 | Second format only: 0 = per errored bit, 1 = per errored word |
| frame_stb | input | NUM_TRIB | One-cycle frame strobe, one bit per tributary |
| oof | input | NUM_TRIB | Out-of-frame status per tributary |
| err_bits | input | NUM_TRIB*EB_W | Errored alignment bit count per tributary, tributary t in slice t |
| par_err | input | NUM_TRIB | Parity error seen in this frame, per tributary |
| rd_stb | input | NUM_TRIB | Latch-and-clear read strobe per tributary |
| hold_align | output | NUM_TRIB*CNT_W | Held alignment error counts |
| hold_par | output | NUM_TRIB*CNT_W | Held parity error counts |

## Verification
The live counters are not visible at the ports, so a wrong live value shows up only in the holding register one clock after the next read strobe of that tributary. A selection error in the increment logic shows up as a held count that differs from the count predicted from the frames applied since the previous read. A lost or doubled same-cycle increment shows up only on the second read after the collision. A wrap instead of saturation shows up as a small held value after a long run of errored frames.

// File: rtl/fec_pkg.sv
package fec_pkg;

  typedef enum logic {
    FMT_FIRST  = 1'b0,
    FMT_SECOND = 1'b1
  } line_fmt_e;

  typedef enum logic {
    CNT_PER_BIT  = 1'b0,
    CNT_PER_WORD = 1'b1
  } align_mode_e;

endpackage

// File: rtl/fec_incr_sel.sv
module fec_incr_sel
  import fec_pkg::*;
#(
  parameter int EB_W = 4
) (
  input  line_fmt_e         fmt,
  input  align_mode_e       mode,
  input  logic              frame_stb,
  input  logic              oof,
  input  logic [EB_W-1:0]   err_bits,
  input  logic              par_err,
  output logic              align_en,
  output logic [EB_W-1:0]   align_amt,
  output logic              par_en
);

  logic accept;
  logic any_err;

  always_comb begin
    accept  = frame_stb & ~oof;
    any_err = |err_bits;
    if ((fmt == FMT_SECOND) && (mode == CNT_PER_WORD)) begin
      align_amt    = '0;
      align_amt[0] = any_err;
    end else begin
      align_amt = err_bits;
    end
    align_en = accept & (|align_amt);
    par_en   = accept & par_err & (fmt == FMT_SECOND);
  end

endmodule

// File: rtl/fec_sat_cnt.sv
module fec_sat_cnt #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_en,
  input  logic [IW-1:0] inc_amt,
  input  logic          snap,
  output logic [W-1:0]  live,
  output logic [W-1:0]  held
);

  logic [W-1:0] live_q, live_d;
  logic [W-1:0] held_q, held_d;
  logic [W-1:0] inc_ext;
  logic [W:0]   sum;
  logic [W-1:0] sat_sum;
  logic         live_ce;

  always_comb begin
    inc_ext          = '0;
    inc_ext[IW-1:0]  = inc_amt;
    sum              = {1'b0, live_q} + {1'b0, inc_ext};
    sat_sum          = sum[W] ? {W{1'b1}} : sum[W-1:0];
    live_ce          = inc_en | snap;
    held_d           = live_q;
    if (snap) begin
      live_d = inc_en ? inc_ext : '0;
    end else begin
      live_d = sat_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      held_q <= '0;
    end else begin
      if (live_ce) live_q <= live_d;
      if (snap)    held_q <= held_d;
    end
  end

  assign live = live_q;
  assign held = held_q;

endmodule

// File: rtl/fec_monitor.sv
module fec_monitor
  import fec_pkg::*;
#(
  parameter int NUM_TRIB = 7,
  parameter int CNT_W    = 16,
  parameter int EB_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fmt_sel,
  input  logic                       word_mode,
  input  logic [NUM_TRIB-1:0]        frame_stb,
  input  logic [NUM_TRIB-1:0]        oof,
  input  logic [NUM_TRIB*EB_W-1:0]   err_bits,
  input  logic [NUM_TRIB-1:0]        par_err,
  input  logic [NUM_TRIB-1:0]        rd_stb,
  output logic [NUM_TRIB*CNT_W-1:0]  hold_align,
  output logic [NUM_TRIB*CNT_W-1:0]  hold_par
);

  localparam int ALIGN_BUS_W = NUM_TRIB * CNT_W;

  line_fmt_e   fmt_e;
  align_mode_e mode_e;

  logic [ALIGN_BUS_W-1:0] live_align;
  logic [ALIGN_BUS_W-1:0] live_par;

  assign fmt_e  = line_fmt_e'(fmt_sel);
  assign mode_e = align_mode_e'(word_mode);

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_trib
    logic            a_en;
    logic [EB_W-1:0] a_amt;
    logic            p_en;

    fec_incr_sel #(.EB_W(EB_W)) u_sel (
      .fmt       (fmt_e),
      .mode      (mode_e),
      .frame_stb (frame_stb[t]),
      .oof       (oof[t]),
      .err_bits  (err_bits[t*EB_W +: EB_W]),
      .par_err   (par_err[t]),
      .align_en  (a_en),
      .align_amt (a_amt),
      .par_en    (p_en)
    );

    fec_sat_cnt #(.W(CNT_W), .IW(EB_W)) u_align (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (a_en),
      .inc_amt (a_amt),
      .snap    (rd_stb[t]),
      .live    (live_align[t*CNT_W +: CNT_W]),
      .held    (hold_align[t*CNT_W +: CNT_W])
    );

    fec_sat_cnt #(.W(CNT_W), .IW(1)) u_par (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (p_en),
      .inc_amt (1'b1),
      .snap    (rd_stb[t]),
      .live    (live_par[t*CNT_W +: CNT_W]),
      .held    (hold_par[t*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/fec_monitor_chk.sv
module fec_monitor_chk #(
  parameter int NUM_TRIB = 7,
  parameter int CNT_W    = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      fmt_sel,
  input logic                      word_mode,
  input logic [NUM_TRIB-1:0]       frame_stb,
  input logic [NUM_TRIB-1:0]       oof,
  input logic [NUM_TRIB-1:0]       rd_stb,
  input logic [NUM_TRIB*CNT_W-1:0] hold_align,
  input logic [NUM_TRIB*CNT_W-1:0] hold_par,
  input logic [NUM_TRIB*CNT_W-1:0] live_align,
  input logic [NUM_TRIB*CNT_W-1:0] live_par
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_TRIB; i++) begin : g_chk
    assert_hold_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb[i] |=> $stable(hold_align[i*CNT_W +: CNT_W]) && $stable(hold_par[i*CNT_W +: CNT_W]));

    assert_hold_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb[i] |=> (hold_align[i*CNT_W +: CNT_W] == $past(live_align[i*CNT_W +: CNT_W]))
                 && (hold_par[i*CNT_W +: CNT_W] == $past(live_par[i*CNT_W +: CNT_W])));

    assert_oof_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (oof[i] && !rd_stb[i]) |=> $stable(live_align[i*CNT_W +: CNT_W]) && $stable(live_par[i*CNT_W +: CNT_W]));

    assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb[i] && !rd_stb[i]) |=> $stable(live_align[i*CNT_W +: CNT_W]) && $stable(live_par[i*CNT_W +: CNT_W]));

    assert_par_fmt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fmt_sel && !rd_stb[i]) |=> $stable(live_par[i*CNT_W +: CNT_W]));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (live_align[i*CNT_W +: CNT_W] == CMAX && !rd_stb[i]) |=> (live_align[i*CNT_W +: CNT_W] == CMAX));

    assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sel && word_mode && !rd_stb[i])
      |=> ({1'b0, live_align[i*CNT_W +: CNT_W]} <= ({1'b0, $past(live_align[i*CNT_W +: CNT_W])} + 1'b1)));
  end

endmodule

bind fec_monitor fec_monitor_chk #(.NUM_TRIB(NUM_TRIB), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_sel    (fmt_sel),
  .word_mode  (word_mode),
  .frame_stb  (frame_stb),
  .oof        (oof),
  .rd_stb     (rd_stb),
  .hold_align (hold_align),
  .hold_par   (hold_par),
  .live_align (live_align),
  .live_par   (live_par)
);

// File: tb/sim_fec_monitor.sv
module sim_fec_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 7;
  localparam int CW = 16;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fmt_sel, word_mode;
  logic [NT-1:0] frame_stb, oof, par_err, rd_stb;
  logic [NT*EW-1:0] err_bits;
  logic [NT*CW-1:0] hold_align, hold_par;

  int checks = 0;
  int errors = 0;

  // fmt, mode, oof, par, err[3:0], expected align[3:0], expected par
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd3,  4'd3,  1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'd5,  4'd5,  1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd4,  4'd4,  1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd4,  4'd1,  1'b0},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd0,  1'b1},
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 4'd15, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b1, 4'd7,  4'd0,  1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd2,  4'd0,  1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd1,  4'd1,  1'b0}
  };

  fec_monitor #(.NUM_TRIB(NT), .CNT_W(CW), .EB_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .word_mode(word_mode),
    .frame_stb(frame_stb), .oof(oof), .err_bits(err_bits), .par_err(par_err),
    .rd_stb(rd_stb), .hold_align(hold_align), .hold_par(hold_par)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ha(input int t);
    return int'(hold_align[t*CW +: CW]);
  endfunction

  function automatic int hp(input int t);
    return int'(hold_par[t*CW +: CW]);
  endfunction

  task automatic do_frame(input int t, input logic [EW-1:0] e, input logic p);
    frame_stb[t] = 1'b1;
    err_bits[t*EW +: EW] = e;
    par_err[t] = p;
    @(negedge clk);
    frame_stb[t] = 1'b0;
    err_bits[t*EW +: EW] = '0;
    par_err[t] = 1'b0;
  endtask

  task automatic do_read(input int t);
    rd_stb[t] = 1'b1;
    @(negedge clk);
    rd_stb[t] = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    fmt_sel = 1'b0; word_mode = 1'b0;
    frame_stb = '0; oof = '0; par_err = '0; rd_stb = '0; err_bits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of holding registers and of the live counters
    check("R1 hold_align all", (hold_align == '0) ? 1 : 0, 1);
    check("R1 hold_par all", (hold_par == '0) ? 1 : 0, 1);
    do_read(3);
    check("R1 first read align", ha(3), 0);

    // table walk on tributary 0: R2 R3 R4 R5 R6
    for (int v = 0; v < 10; v++) begin
      logic f, m, o, p;
      logic [3:0] e, ea;
      logic ep;
      {f, m, o, p, e, ea, ep} = VEC[v];
      fmt_sel = f; word_mode = m; oof[0] = o;
      do_frame(0, e, p);
      oof[0] = 1'b0;
      do_read(0);
      check($sformatf("R2/R3/R4/R6 align vec%0d", v), ha(0), int'(ea));
      check($sformatf("R5/R6 parity vec%0d", v), hp(0), int'(ep));
    end

    // R10: values without a strobe are ignored
    fmt_sel = 1'b1; word_mode = 1'b0;
    err_bits[0 +: EW] = 4'd9; par_err[0] = 1'b1;
    repeat (3) @(negedge clk);
    err_bits[0 +: EW] = '0; par_err[0] = 1'b0;
    do_read(0);
    check("R10 align no strobe", ha(0), 0);
    check("R10 parity no strobe", hp(0), 0);

    // R8: increment in the read cycle is kept for the next read
    do_frame(0, 4'd5, 1'b1);
    frame_stb[0] = 1'b1; err_bits[0 +: EW] = 4'd3; par_err[0] = 1'b1; rd_stb[0] = 1'b1;
    @(negedge clk);
    frame_stb[0] = 1'b0; err_bits[0 +: EW] = '0; par_err[0] = 1'b0; rd_stb[0] = 1'b0;
    check("R8 snapshot align", ha(0), 5);
    check("R8 snapshot parity", hp(0), 1);
    repeat (2) @(negedge clk);
    check("R8 hold steady", ha(0), 5);
    do_read(0);
    check("R8 carried align", ha(0), 3);
    check("R8 carried parity", hp(0), 1);

    // R9: independence of tributaries, R2 accumulation
    fmt_sel = 1'b0; word_mode = 1'b1;
    for (int k = 0; k < 3; k++) do_frame(1, 4'd2, 1'b1);
    do_read(0);
    check("R9 other trib align", ha(0), 0);
    check("R9 unread hold", ha(1), 0);
    do_read(1);
    check("R9 trib1 align sum", ha(1), 6);
    check("R9 trib1 parity first format", hp(1), 0);

    // R7: saturation on tributary 2
    fmt_sel = 1'b1; word_mode = 1'b0;
    frame_stb[2] = 1'b1; err_bits[2*EW +: EW] = 4'd15; par_err[2] = 1'b1;
    repeat (4379) @(negedge clk);
    frame_stb[2] = 1'b0; err_bits[2*EW +: EW] = '0; par_err[2] = 1'b0;
    do_read(2);
    check("R7 align saturated", ha(2), 65535);
    check("R7 parity count", hp(2), 4379);
    do_read(2);
    check("R7 cleared after read", ha(2), 0);

    finish_run();
  end

endmodule